// File: doc/BRIEF.md
# Multi-function 8-bit shift register

This block is an 8-bit clocked register with two 1-bit side flags. The high-side flag catches an adder carry, a subtractor borrow, or the bit that leaves the value on the left. The low-side flag catches the bit that leaves the value on the right. A control vector of fifteen bits selects one operation per clock: clear, parallel load, increment, decrement, add, subtract, invert, serial entry at either end, logical and arithmetic shifts, and rotates in both directions.

The host drives a data word, two serial-entry bits and the control vector. On each rising clock edge the register and flags take the result of the selected operation. When no control bit is set, everything holds. When several control bits are set, the lowest-numbered one is carried out and the rest are ignored. Reset is synchronous and active-low.

Top module: `mfreg_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `q`, `hi_flag` and `lo_flag` all become 0 on that edge, whatever the other inputs are.
- R2: When `ctrl` is all zeros, `q`, `hi_flag` and `lo_flag` keep their values, whatever `din`, `ser_lo` and `ser_hi` are.
- R3: When more than one bit of `ctrl` is set, only the operation of the lowest-numbered set bit takes effect. The bit positions are: 0 clear, 1 load, 2 increment, 3 decrement, 4 add, 5 subtract, 6 invert, 7 serial entry at bit 0, 8 serial entry at bit 7, 9 logical left shift, 10 logical right shift, 11 arithmetic left shift, 12 arithmetic right shift, 13 rotate left, 14 rotate right.
- R4: Clear (bit 0) sets `q` to 8'h00 and both flags to 0.
- R5: Load (bit 1) copies `din` into `q` and leaves both flags unchanged.
- R6: Increment (bit 2) sets `q` to q+1 and decrement (bit 3) sets `q` to q-1, both modulo 256. Neither changes a flag.
- R7: Add (bit 4) sets {hi_flag,q} to q+din, with the carry in `hi_flag`. Subtract (bit 5) sets `q` to q-din modulo 256 and sets `hi_flag` to 1 exactly when din>q. Neither changes `lo_flag`.
- R8: Invert (bit 6) replaces `q` with its bitwise complement and leaves both flags unchanged, so two inverts restore the value.
- R9: Serial entry at bit 0 (bit 7) sets `q` to {q[6:0],ser_lo} and `hi_flag` to the old q[7]. Serial entry at bit 7 (bit 8) sets `q` to {ser_hi,q[7:1]} and `lo_flag` to the old q[0].
- R10: Logical and arithmetic left shifts (bits 9 and 11) set `q` to {q[6:0],0} and `hi_flag` to the old q[7]. Logical right shift (bit 10) sets `q` to {0,q[7:1]} and `lo_flag` to the old q[0].
- R11: Arithmetic right shift (bit 12) sets `q` to {q[7],q[7:1]} and `lo_flag` to the old q[0]. The serial-entry bits have no effect on it.
- R12: Rotate left (bit 13) sets `q` to {q[6:0],q[7]} and `hi_flag` to the old q[7]. Rotate right (bit 14) sets `q` to {q[0],q[7:1]} and `lo_flag` to the old q[0].
- R13: A flag that an operation above does not name keeps its value through that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 8 | Data word for load, add and subtract |
| ser_lo | input | 1 | Serial bit entering at bit 0 |
| ser_hi | input | 1 | Serial bit entering at bit 7 |
| ctrl | input | 15 | Operation select, one bit per operation |
| q | output | 8 | Register value |
| hi_flag | output | 1 | Carry, borrow or bit shifted out on the left |
| lo_flag | output | 1 | Bit shifted out on the right |

## Verification
The clocked properties compare each result with the register and inputs one cycle earlier. They therefore take for granted that the block was reset before its first operation, so every earlier value is known, and that `ctrl`, `din` and the serial bits are steady at the rising edge. The stimulus meets both conditions. It opens with a reset, and it changes all inputs only at falling edges. Several of its cycles set multiple control bits on purpose, and the priority-aware properties are written to hold under those overlaps. Each property's antecedent demands that the lower-numbered control bits are clear, so it only fires when its own operation is the one that wins.

// File: rtl/mfreg_pkg.sv
// Package: shared widths, operation codes and state type for the
// multi-function register. Assumes exactly one operation per code.
package mfreg_pkg;
    localparam int DATA_W   = 8;
    localparam int OP_COUNT = 15;
    localparam int OP_W     = $clog2(OP_COUNT);

    // Operation codes equal the control bit that selects them.
    typedef enum logic [OP_W-1:0] {
        OP_CLR  = 4'd0,
        OP_LD   = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_ADD  = 4'd4,
        OP_SUB  = 4'd5,
        OP_INV  = 4'd6,
        OP_SILO = 4'd7,
        OP_SIHI = 4'd8,
        OP_LSL  = 4'd9,
        OP_LSR  = 4'd10,
        OP_ASL  = 4'd11,
        OP_ASR  = 4'd12,
        OP_ROL  = 4'd13,
        OP_ROR  = 4'd14
    } op_e;

    // Register contents: value plus the two side flags.
    typedef struct packed {
        logic              hi;
        logic [DATA_W-1:0] val;
        logic              lo;
    } reg_state_t;
endpackage

// File: rtl/mfreg_pick.sv
// Module: picks the lowest-numbered set control bit and reports it
// as an operation code. Assumes N is at most 2**OP_W.
module mfreg_pick
    import mfreg_pkg::*;
#(
    parameter int N = OP_COUNT
) (
    input  logic [N-1:0] ctrl,
    output op_e          op,
    output logic         any
);
    // Masks of control bits seen below each position.
    logic [N:0] seen;
    logic [N-1:0] grant;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = ctrl[i] & ~seen[i];
        assign seen[i+1] = seen[i] | ctrl[i];
    end

    assign any = seen[N];

    // Encode the single granted bit into an operation code.
    always_comb begin
        logic [OP_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | OP_W'(i);
        end
        op = op_e'(idx);
    end
endmodule

// File: rtl/mfreg_arith.sv
// Module: shared adder/subtractor for increment, decrement, add and
// subtract. The extra top bit is carry for sums and borrow for
// differences. Assumes op is one of the four arithmetic codes when used.
module mfreg_arith
    import mfreg_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         cy
);
    localparam logic [W-1:0] ONE = W'(1);

    logic         use_one;
    logic         do_sub;
    logic [W-1:0] opnd;
    logic [W:0]   wide;

    // Select the second operand and the direction.
    always_comb begin
        use_one = (op == OP_INC) || (op == OP_DEC);
        do_sub  = (op == OP_DEC) || (op == OP_SUB);
        opnd    = use_one ? ONE : b;
    end

    // One W+1 bit add or subtract; bit W is carry or borrow.
    always_comb begin
        if (do_sub) wide = {1'b0, a} - {1'b0, opnd};
        else        wide = {1'b0, a} + {1'b0, opnd};
    end

    assign res = wide[W-1:0];
    assign cy  = wide[W];
endmodule

// File: rtl/mfreg_shift.sv
// Module: one-place shifter and rotator. Gives the shifted value for
// every shift-like code, and the bits leaving each end. Assumes op is a
// shift, rotate or serial-entry code when its result is used.
module mfreg_shift
    import mfreg_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic         ser_lo,
    input  logic         ser_hi,
    output logic [W-1:0] res,
    output logic         out_hi,
    output logic         out_lo
);
    logic left;
    logic fill;

    // Pick direction and the bit entering the vacated end.
    always_comb begin
        left = 1'b0;
        fill = 1'b0;
        unique case (op)
            OP_SILO: begin left = 1'b1; fill = ser_lo;   end
            OP_SIHI: begin left = 1'b0; fill = ser_hi;   end
            OP_LSL,
            OP_ASL:  begin left = 1'b1; fill = 1'b0;     end
            OP_LSR:  begin left = 1'b0; fill = 1'b0;     end
            OP_ASR:  begin left = 1'b0; fill = a[W-1];   end
            OP_ROL:  begin left = 1'b1; fill = a[W-1];   end
            OP_ROR:  begin left = 1'b0; fill = a[0];     end
            default: begin left = 1'b0; fill = 1'b0;     end
        endcase
    end

    // Form the shifted word.
    always_comb begin
        if (left) res = {a[W-2:0], fill};
        else      res = {fill, a[W-1:1]};
    end

    assign out_hi = a[W-1];
    assign out_lo = a[0];
endmodule

// File: rtl/mfreg_top.sv
// Module: multi-function register top. Decodes the control vector with
// lowest-bit priority, computes the next value and flags, and stores
// them on the rising clock. Synchronous active-low reset. Assumes the
// inputs are steady at the rising edge.
module mfreg_top
    import mfreg_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = OP_COUNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         ser_lo,
    input  logic         ser_hi,
    input  logic [N-1:0] ctrl,
    output logic [W-1:0] q,
    output logic         hi_flag,
    output logic         lo_flag
);
    op_e          op;
    logic         any;
    logic [W-1:0] ar_res;
    logic         ar_cy;
    logic [W-1:0] sh_res;
    logic         sh_hi;
    logic         sh_lo;
    reg_state_t   cur;
    reg_state_t   nxt;

    mfreg_pick #(.N(N)) u_pick (
        .ctrl (ctrl),
        .op   (op),
        .any  (any)
    );

    mfreg_arith #(.W(W)) u_arith (
        .op  (op),
        .a   (cur.val),
        .b   (din),
        .res (ar_res),
        .cy  (ar_cy)
    );

    mfreg_shift #(.W(W)) u_shift (
        .op     (op),
        .a      (cur.val),
        .ser_lo (ser_lo),
        .ser_hi (ser_hi),
        .res    (sh_res),
        .out_hi (sh_hi),
        .out_lo (sh_lo)
    );

    // Next state: only the flags an operation names are rewritten.
    always_comb begin
        nxt = cur;
        unique case (op)
            OP_CLR: begin
                nxt.val = '0;
                nxt.hi  = 1'b0;
                nxt.lo  = 1'b0;
            end
            OP_LD:  nxt.val = din;
            OP_INC,
            OP_DEC: nxt.val = ar_res;
            OP_ADD,
            OP_SUB: begin
                nxt.val = ar_res;
                nxt.hi  = ar_cy;
            end
            OP_INV: nxt.val = ~cur.val;
            OP_SILO,
            OP_LSL,
            OP_ASL,
            OP_ROL: begin
                nxt.val = sh_res;
                nxt.hi  = sh_hi;
            end
            OP_SIHI,
            OP_LSR,
            OP_ASR,
            OP_ROR: begin
                nxt.val = sh_res;
                nxt.lo  = sh_lo;
            end
            default: nxt = cur;
        endcase
    end

    // State register: reset clears, idle holds, otherwise update.
    always_ff @(posedge clk) begin
        if (!rst_n)   cur <= '0;
        else if (any) cur <= nxt;
    end

    assign q       = cur.val;
    assign hi_flag = cur.hi;
    assign lo_flag = cur.lo;
endmodule

// File: rtl/mfreg_chk.sv
// Checker: cycle-to-cycle properties of the multi-function register,
// seen at its ports. Assumes a reset precedes the first operation.
module mfreg_chk #(
    parameter int W = 8,
    parameter int N = 15
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] din,
    input logic         ser_lo,
    input logic [N-1:0] ctrl,
    input logic [W-1:0] q,
    input logic         hi_flag,
    input logic         lo_flag
);
    // R1: reset zeroes value and flags
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (q == '0 && !hi_flag && !lo_flag));

    // R2: idle holds everything
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == '0) |=> ($stable(q) && $stable(hi_flag) && $stable(lo_flag)));

    // R3: clear beats any higher-numbered bit
    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && $countones(ctrl) > 1) |=> (q == '0 && !hi_flag && !lo_flag));

    // R4: clear
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[0] |=> (q == '0 && !hi_flag && !lo_flag));

    // R6: increment wraps and keeps flags
    a_r6_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[2:0] == 3'b100) |=>
        (q == $past(q) + W'(1) && $stable(hi_flag) && $stable(lo_flag)));

    // R7: add produces carry in the high flag
    a_r7_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[4:0] == 5'b10000) |=>
        ({hi_flag, q} == ({1'b0, $past(q)} + {1'b0, $past(din)}) && $stable(lo_flag)));

    // R9: serial entry at bit 0
    a_r9_serial_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[7:0] == 8'h80) |=>
        (q[0] == $past(ser_lo) && hi_flag == $past(q[W-1]) && $stable(lo_flag)));

    // R11: arithmetic right shift keeps the sign
    a_r11_sign_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[12:0] == 13'h1000) |=>
        (q[W-1] == $past(q[W-1]) && lo_flag == $past(q[0]) && $stable(hi_flag)));

    // R12: rotate left carries bit 7 round and into the high flag
    a_r12_rotate_left: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[13:0] == 14'h2000) |=>
        (q[0] == $past(q[W-1]) && hi_flag == $past(q[W-1])));
endmodule

bind mfreg_top mfreg_chk #(.W(W), .N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .ser_lo  (ser_lo),
    .ctrl    (ctrl),
    .q       (q),
    .hi_flag (hi_flag),
    .lo_flag (lo_flag)
);

// File: tb/mfreg_top_test.sv
// Bench: scoreboard. The driver computes expected results from the
// requirements and queues them; the monitor compares after each edge.
module mfreg_top_test;
    localparam int W = 8;
    localparam int N = 15;

    typedef struct {
        logic [W-1:0] q;
        logic         hi;
        logic         lo;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0;
    logic         ser_lo = 1'b0;
    logic         ser_hi = 1'b0;
    logic [N-1:0] ctrl = '0;
    logic [W-1:0] q;
    logic         hi_flag;
    logic         lo_flag;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    // Model state built from the requirements.
    logic [W-1:0] m_q = '0;
    logic         m_hi = 1'b0;
    logic         m_lo = 1'b0;

    mfreg_top uut (
        .clk(clk), .rst_n(rst_n), .din(din), .ser_lo(ser_lo),
        .ser_hi(ser_hi), .ctrl(ctrl), .q(q), .hi_flag(hi_flag),
        .lo_flag(lo_flag)
    );

    always #10 clk = ~clk;

    // Advance the model by one operation.
    task automatic model(input logic [N-1:0] c, input logic [W-1:0] d,
                         input logic sl, input logic sh);
        int sel;
        logic [W:0] t;
        sel = -1;
        for (int i = N - 1; i >= 0; i--) if (c[i]) sel = i;
        case (sel)
            0:  begin m_q = '0; m_hi = 0; m_lo = 0; end
            1:  m_q = d;
            2:  m_q = m_q + 8'd1;
            3:  m_q = m_q - 8'd1;
            4:  begin t = {1'b0, m_q} + {1'b0, d}; m_q = t[W-1:0]; m_hi = t[W]; end
            5:  begin m_hi = (d > m_q); m_q = m_q - d; end
            6:  m_q = ~m_q;
            7:  begin m_hi = m_q[7]; m_q = {m_q[6:0], sl}; end
            8:  begin m_lo = m_q[0]; m_q = {sh, m_q[7:1]}; end
            9, 11: begin m_hi = m_q[7]; m_q = {m_q[6:0], 1'b0}; end
            10: begin m_lo = m_q[0]; m_q = {1'b0, m_q[7:1]}; end
            12: begin m_lo = m_q[0]; m_q = {m_q[7], m_q[7:1]}; end
            13: begin m_hi = m_q[7]; m_q = {m_q[6:0], m_q[7]}; end
            14: begin m_lo = m_q[0]; m_q = {m_q[0], m_q[7:1]}; end
            default: ;
        endcase
    endtask

    // Driver: apply one cycle of stimulus and queue its expected result.
    task automatic step(input logic [N-1:0] c, input logic [W-1:0] d,
                        input logic sl, input logic sh, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b1; ctrl = c; din = d; ser_lo = sl; ser_hi = sh;
        model(c, d, sl, sh);
        e.q = m_q; e.hi = m_hi; e.lo = m_lo; e.tag = tag;
        sb.push_back(e);
    endtask

    // Driver: one reset cycle with busy inputs.
    task automatic do_reset(input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0; ctrl = 15'h7FFE; din = 8'hA5; ser_lo = 1; ser_hi = 1;
        m_q = '0; m_hi = 0; m_lo = 0;
        e.q = 0; e.hi = 0; e.lo = 0; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare outputs shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (q !== e.q || hi_flag !== e.hi || lo_flag !== e.lo) begin
                bad++;
                $display("FAIL %s: got q=%b hi=%b lo=%b expected q=%b hi=%b lo=%b",
                         e.tag, q, hi_flag, lo_flag, e.q, e.hi, e.lo);
            end
        end
    end

    // Stimulus sequence.
    initial begin
        do_reset("R1 reset");
        step(15'h0002, 8'h9D, 0, 0, "R5 load");
        step(15'h0004, 8'h00, 0, 0, "R6 inc");
        step(15'h0004, 8'h00, 0, 0, "R6 inc");
        step(15'h0002, 8'hFF, 0, 0, "R5 load");
        step(15'h0004, 8'h00, 0, 0, "R6 inc wrap");
        step(15'h0008, 8'h00, 0, 0, "R6 dec wrap");
        step(15'h0002, 8'hE0, 0, 0, "R5 load");
        step(15'h0008, 8'h00, 0, 0, "R6 dec");
        step(15'h0008, 8'h00, 0, 0, "R6 dec");
        step(15'h0002, 8'h42, 0, 0, "R5 load");
        step(15'h0020, 8'h3B, 0, 0, "R7 sub");
        step(15'h0020, 8'h3B, 0, 0, "R7 sub borrow");
        step(15'h0002, 8'hF0, 1, 1, "R13 load keeps flags");
        step(15'h0010, 8'h20, 0, 0, "R7 add carry");
        step(15'h0010, 8'h01, 0, 0, "R7 add no carry");
        step(15'h0002, 8'h41, 0, 0, "R5 load");
        step(15'h0040, 8'h00, 0, 0, "R8 invert");
        step(15'h0040, 8'h00, 0, 0, "R8 invert twice");
        step(15'h0000, 8'hFF, 1, 1, "R2 idle");
        step(15'h0000, 8'h13, 0, 1, "R2 idle");
        step(15'h0002, 8'h83, 0, 0, "R5 load");
        step(15'h0080, 8'h00, 1, 0, "R9 serial low 1");
        step(15'h0002, 8'hA7, 0, 0, "R5 load");
        step(15'h0080, 8'h00, 0, 1, "R9 serial low 0");
        step(15'h0100, 8'h00, 0, 1, "R9 serial high 1");
        step(15'h0100, 8'h00, 1, 0, "R9 serial high 0");
        step(15'h0002, 8'hC3, 0, 0, "R5 load");
        step(15'h0200, 8'h00, 1, 1, "R10 logical left");
        step(15'h0400, 8'h00, 1, 1, "R10 logical right");
        step(15'h0800, 8'h00, 1, 1, "R10 arith left");
        step(15'h0001, 8'h00, 0, 0, "R4 clear");
        step(15'h0002, 8'h80, 0, 0, "R5 load");
        step(15'h1000, 8'h00, 0, 0, "R11 arith right sign 1");
        step(15'h1000, 8'h00, 1, 1, "R11 arith right serial ignored");
        step(15'h0002, 8'h41, 0, 0, "R5 load");
        step(15'h1000, 8'h00, 1, 1, "R11 arith right sign 0");
        step(15'h1000, 8'h00, 1, 0, "R11 arith right");
        step(15'h0002, 8'h96, 0, 0, "R5 load");
        step(15'h2000, 8'h00, 0, 0, "R12 rotate left");
        step(15'h2000, 8'h00, 0, 0, "R12 rotate left");
        step(15'h4000, 8'h00, 0, 0, "R12 rotate right");
        step(15'h4000, 8'h00, 0, 0, "R12 rotate right");
        step(15'h0021, 8'h55, 1, 1, "R3 clear beats sub");
        step(15'h0006, 8'h7E, 0, 0, "R3 load beats inc");
        step(15'h4080, 8'h00, 1, 0, "R3 serial low beats rotate");
        step(15'h1800, 8'h00, 0, 0, "R3 arith left beats arith right");
        step(15'h0050, 8'h10, 0, 0, "R3 add beats invert");
        do_reset("R1 reset mid-run");
        step(15'h0000, 8'h00, 0, 0, "R2 idle after reset");
        repeat (3) @(negedge clk);
        ctrl = '0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule